// File: doc/BRIEF.md
# Delay-Locked Loop Tap Controller

This block steers a 256-position digital delay line so that a returned feedback clock edge lands on the reference clock edge. A phase detector outside the block compares the two edges and, on each strobe it raises, says whether the feedback came too early or too late. The controller answers by moving the selected tap one position: an early edge asks for more delay, and a late edge asks for less.

While it is acquiring, the controller moves the tap on every detector sample. Once it sees the detector flip direction on several samples in a row, the edge is hunting across the alignment point. The controller then raises its lock flag. After lock it keeps correcting for slow voltage and temperature drift. It takes at most one step per update interval, and any sample that arrives between updates is dropped.

A correction that would push the tap past either end of the line is refused. The tap stays where it is, the lock flag falls and a sticky error flag rises. Only a reset clears that state. Downstream logic should treat the delayed clock as usable only while the lock flag is high.

Top module: `dll_tap_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `tap_o` equals START_TAP (default 128), `locked_o` is 0 and `tap_err_o` is 0.
- R2: Before lock, a sample with `sample_vld_i`=1 and `fb_early_i`=1 raises `tap_o` by one at the next clock edge. With `fb_early_i`=0 it lowers `tap_o` by one.
- R3: `tap_o` never moves by more than one position per clock. It does not change on an edge where `sample_vld_i` was 0.
- R4: `locked_o` rises on the edge of the valid sample that completes LOCK_CNT (default 4) reversals in a row. A reversal is a sample whose direction is the opposite of the previous sample's. Starting from START_TAP, lock comes within 140 samples for any alignment point in range.
- R5: Before lock, a sample with the same direction as the previous sample resets the reversal run to zero.
- R6: After lock, a valid sample moves the tap only when at least UPD_INTERVAL (default 16) clocks have passed since lock or since the last step. Any other sample leaves `tap_o` unchanged.
- R7: After lock, slow drift of the alignment point is followed one tap per update, and `locked_o` stays high while corrections remain in range.
- R8: A step that would take `tap_o` below 0 or above 255 leaves `tap_o` unchanged, sets `tap_err_o` and clears `locked_o`. Both stay that way, and later samples are ignored, until reset.
- R9: `fb_early_i` encodes the detector verdict: 1 means the feedback is early and more delay is needed, 0 means it is late and less delay is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_vld_i | input | 1 | Phase detector sample strobe, one cycle per sample |
| fb_early_i | input | 1 | Detector verdict: 1 early, 0 late |
| tap_o | output | 8 | Selected delay-line tap |
| locked_o | output | 1 | Feedback aligned to reference |
| tap_err_o | output | 1 | Sticky tap-range overrun flag |

## Verification
The assertions check the per-cycle rules on every edge. They confirm single-position steps in the direction the sample requested and no motion without a sample. They also confirm that lock rises only on a sample, that a post-lock step only happens when the update timer has expired, and that the error flag stays set, freezes the tap and excludes lock. Other properties only show up over many samples: reaching lock within a bounded number of samples, the reset of the reversal run, following drift without losing lock, and the refused overrun at each end. For these the bench closes the loop through a behavioural delay line of a fixed offset plus 40 ps per tap.

// File: rtl/dll_pkg.sv
package dll_pkg;
  typedef enum logic {
    DIR_LATE  = 1'b0,
    DIR_EARLY = 1'b1
  } dir_e;
endpackage

// File: rtl/dll_tap_stepper.sv
module dll_tap_stepper
  import dll_pkg::*;
#(
  parameter int TAP_W     = 8,
  parameter int START_TAP = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  dir_e             dir_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             err_o,
  output logic             step_o,
  output logic             hit_o
);
  localparam logic [TAP_W-1:0] TAP_MAX  = {TAP_W{1'b1}};
  localparam logic [TAP_W-1:0] TAP_INIT = TAP_W'(START_TAP);

  logic at_edge;

  always_comb begin
    at_edge = (dir_i == DIR_EARLY) ? (tap_o == TAP_MAX) : (tap_o == '0);
    hit_o   = req_i & at_edge;
    step_o  = req_i & ~at_edge;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_o <= TAP_INIT;
      err_o <= 1'b0;
    end else if (hit_o) begin
      err_o <= 1'b1;
    end else if (step_o) begin
      tap_o <= (dir_i == DIR_EARLY) ? tap_o + 1'b1 : tap_o - 1'b1;
    end
  end
endmodule

// File: rtl/dll_lock_detect.sv
module dll_lock_detect
  import dll_pkg::*;
#(
  parameter int LOCK_CNT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  dir_e dir_i,
  input  logic fault_i,
  output logic locked_o
);
  localparam int CW = $clog2(LOCK_CNT + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CNT - 1);

  logic [CW-1:0] rev_cnt;
  logic          have_prev;
  dir_e          prev_dir;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o  <= 1'b0;
      rev_cnt   <= '0;
      have_prev <= 1'b0;
      prev_dir  <= DIR_LATE;
    end else if (fault_i) begin
      locked_o <= 1'b0;
    end else if (!locked_o && step_i) begin
      have_prev <= 1'b1;
      prev_dir  <= dir_i;
      if (have_prev && (dir_i != prev_dir)) begin
        if (rev_cnt == LAST) locked_o <= 1'b1;
        rev_cnt <= rev_cnt + 1'b1;
      end else begin
        rev_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/dll_upd_timer.sv
module dll_upd_timer #(
  parameter int UPD_INTERVAL = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic step_i,
  output logic due_o
);
  localparam int CW = $clog2(UPD_INTERVAL + 1);
  localparam logic [CW-1:0] FULL = CW'(UPD_INTERVAL);

  logic [CW-1:0] cnt;

  assign due_o = (cnt == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt <= '0;
    else if (!run_i || step_i)  cnt <= '0;
    else if (!due_o)            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dll_tap_ctrl.sv
module dll_tap_ctrl
  import dll_pkg::*;
#(
  parameter int TAP_W        = 8,
  parameter int START_TAP    = 128,
  parameter int LOCK_CNT     = 4,
  parameter int UPD_INTERVAL = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_vld_i,
  input  logic             fb_early_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             locked_o,
  output logic             tap_err_o
);
  dir_e dir;
  logic req, step, hit, upd_due;

  assign dir = fb_early_i ? DIR_EARLY : DIR_LATE;
  // acquisition steps on every sample, tracking only on timer expiry
  assign req = sample_vld_i & ~tap_err_o & (~locked_o | upd_due);

  dll_tap_stepper #(
    .TAP_W    (TAP_W),
    .START_TAP(START_TAP)
  ) u_stepper (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req),
    .dir_i (dir),
    .tap_o (tap_o),
    .err_o (tap_err_o),
    .step_o(step),
    .hit_o (hit)
  );

  dll_lock_detect #(
    .LOCK_CNT(LOCK_CNT)
  ) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .dir_i   (dir),
    .fault_i (hit | tap_err_o),
    .locked_o(locked_o)
  );

  dll_upd_timer #(
    .UPD_INTERVAL(UPD_INTERVAL)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (locked_o),
    .step_i(step),
    .due_o (upd_due)
  );
endmodule

// File: rtl/dll_tap_ctrl_chk.sv
module dll_tap_ctrl_chk #(
  parameter int TAP_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vld_i,
  input logic             early_i,
  input logic [TAP_W-1:0] tap_i,
  input logic             locked_i,
  input logic             err_i,
  input logic             due_i
);
  localparam logic [TAP_W-1:0] ONE = TAP_W'(1);

  AST_ONE_TAP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_i != $past(tap_i)) |-> ((tap_i - $past(tap_i)) == ONE || ($past(tap_i) - tap_i) == ONE)); // R3
  AST_NO_STEP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(vld_i) |-> $stable(tap_i)); // R3
  AST_STEP_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(vld_i) && (tap_i != $past(tap_i))) |->
      (tap_i == ($past(early_i) ? $past(tap_i) + ONE : $past(tap_i) - ONE))); // R2
  AST_LOCK_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_i) |-> $past(vld_i)); // R4
  AST_TRACK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(locked_i) && (tap_i != $past(tap_i))) |-> $past(due_i)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_i) |-> err_i); // R8
  AST_ERR_NO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !locked_i); // R8
  AST_ERR_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_i) |-> $stable(tap_i)); // R8
endmodule

bind dll_tap_ctrl dll_tap_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .vld_i   (sample_vld_i),
  .early_i (fb_early_i),
  .tap_i   (tap_o),
  .locked_i(locked_o),
  .err_i   (tap_err_o),
  .due_i   (upd_due)
);

// File: tb/dll_tap_ctrl_test.sv
`timescale 1ns/1ps
module dll_tap_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vld = 1'b0;
  logic       early = 1'b0;
  logic [7:0] tap;
  logic       locked, err;

  int total = 0;
  int bad = 0;
  int off_ps = 1000;
  int tgt_ps = 1000;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dll_tap_ctrl #(
    .TAP_W(8), .START_TAP(128), .LOCK_CNT(4), .UPD_INTERVAL(16)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_vld_i(vld), .fb_early_i(early),
    .tap_o(tap), .locked_o(locked), .tap_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic sample(input bit e);
    vld = 1'b1; early = e;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0;
  endtask

  function automatic bit model_early();
    return (off_ps + int'(tap) * 40) < tgt_ps;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic acquire(output int n);
    n = 0;
    while (!locked && n < 300) begin
      sample(model_early());
      n++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(tap == 8'd128, "R1 reset tap", tap, 128);
    chk(locked == 1'b0, "R1 reset locked", locked, 0);
    chk(err == 1'b0, "R1 reset err", err, 0);
  endtask

  task automatic t_step();
    do_reset();
    sample(1'b1);
    chk(tap == 8'd129, "R2 R9 early adds delay", tap, 129);
    sample(1'b0);
    chk(tap == 8'd128, "R2 R9 late removes delay", tap, 128);
    early = 1'b1;
    idle(5);
    chk(tap == 8'd128, "R3 no strobe no motion", tap, 128);
  endtask

  task automatic t_reversal();
    do_reset();
    sample(1'b1); sample(1'b0); sample(1'b0);
    sample(1'b1); sample(1'b0); sample(1'b1);
    chk(locked == 1'b0, "R5 repeat restarts run", locked, 0);
    chk(tap == 8'd128, "R5 tap after pattern", tap, 128);
    sample(1'b0);
    chk(locked == 1'b1, "R4 lock on fourth reversal", locked, 1);
    chk(tap == 8'd127, "R4 tap at lock", tap, 127);
    // R6: sample right after lock is dropped
    sample(1'b1);
    chk(tap == 8'd127, "R6 early sample ignored", tap, 127);
    idle(20);
    sample(1'b1);
    chk(tap == 8'd128, "R6 step after interval", tap, 128);
    sample(1'b1);
    chk(tap == 8'd128, "R6 interval restarts", tap, 128);
  endtask

  task automatic t_acquire_drift();
    int n;
    bit dropped;
    do_reset();
    off_ps = 1000;
    tgt_ps = 1000 + 150 * 40 + 20;
    acquire(n);
    chk(locked == 1'b1, "R4 locked", locked, 1);
    chk(n <= 140, "R4 lock sample bound", n, 140);
    chk(tap == 8'd150 || tap == 8'd151, "R4 lock position", tap, 150);
    dropped = 1'b0;
    for (int s = 0; s < 5; s++) begin
      tgt_ps += 40;
      for (int k = 0; k < 30; k++) begin
        sample(model_early());
        if (!locked) dropped = 1'b1;
        idle(3);
      end
    end
    chk(!dropped, "R7 lock held through drift", dropped, 0);
    chk(err == 1'b0, "R7 no error in drift", err, 0);
    chk(tap >= 8'd154 && tap <= 8'd157, "R7 tap followed drift", tap, 155);
  endtask

  task automatic t_upper();
    do_reset();
    for (int k = 0; k < 127; k++) sample(1'b1);
    chk(tap == 8'd255 && err == 1'b0, "R8 top tap reached", tap, 255);
    chk(locked == 1'b0, "R5 same direction no lock", locked, 0);
    sample(1'b1);
    chk(err == 1'b1, "R8 overrun top flags", err, 1);
    chk(tap == 8'd255, "R8 tap held at top", tap, 255);
    sample(1'b0);
    chk(tap == 8'd255 && err == 1'b1, "R8 samples ignored after error", tap, 255);
    do_reset();
    chk(err == 1'b0 && tap == 8'd128, "R1 reset clears error", err, 0);
  endtask

  task automatic t_lower_locked();
    int n;
    do_reset();
    off_ps = 1000;
    tgt_ps = 1020;
    acquire(n);
    chk(locked == 1'b1 && tap <= 8'd1, "R4 lock near bottom", tap, 0);
    tgt_ps = 900;
    n = 0;
    while (!err && n < 10) begin
      idle(20);
      sample(model_early());
      n++;
    end
    chk(err == 1'b1, "R8 underrun flags", err, 1);
    chk(locked == 1'b0, "R8 lock dropped", locked, 0);
    chk(tap == 8'd0, "R8 tap held at bottom", tap, 0);
  endtask

  initial begin
    t_reset();
    t_step();
    t_reversal();
    t_acquire_drift();
    t_upper();
    t_lower_locked();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule